// File: doc/BRIEF.md
# Crosspoint Switch Control Latch Array

This block is the digital control plane of a 12-row by 8-column crosspoint matrix. It keeps one enable bit for each of the 96 crosspoints and drives them out as a flat vector. The analog switches downstream read this vector. The block holds no analog logic of its own.

Software, or a slower controller, writes the array one crosspoint at a time. It presents a row code and a column code, then raises a strobe. The value on the data line when the strobe falls becomes the new state of the addressed crosspoint. A separate active-high master clear turns every crosspoint off.

All of these control lines are treated as asynchronous. Each one passes through a two-stage synchronizer clocked by the system clock. The falling edge of the strobe is found inside the block. The block also raises a one-cycle flag in two cases: when a strobe names a row that does not exist, and when the address moves while the strobe is high.

Top module: `xpt_latch_array`

## Requirements
- R1: After the system reset `rstN` is released, all 96 enable bits are 0, and `badRow` and `setupViol` are 0.
- R2: Each synchronized falling edge of `strobe` with `dataIn`=1 sets one enable bit. That bit is `switchEn[colSel*12 + rowSel]`, so bit 0 is row 0 of column 0 and bit 95 is row 11 of column 7. The bit changes on the third rising clock edge after the input falls.
- R3: A strobe falling edge with `dataIn`=0 clears the addressed enable bit.
- R4: A strobe cycle changes no other enable bit. No enable bit changes while `strobe` stays high or stays low.
- R5: The value committed is the value `dataIn` holds when `strobe` falls. Changes to `dataIn` while the strobe is high, or after it falls, are not committed.
- R6: While `masterClr` is high, all enable bits go to 0 and stay 0, and strobe falling edges have no effect.
- R7: When `masterClr` rises at the same time as a strobe falling edge, the clear wins and the write is dropped.
- R8: A strobe whose row code is 12 to 15 leaves all 96 bits unchanged. It raises `badRow` for exactly one clock cycle.
- R9: `setupViol` pulses high for one cycle each time the synchronized address changes while the synchronized strobe stays high. It stays low when the address is held steady through a strobe.
- R10: An enable bit keeps its value through any number of strobes to other crosspoints, until it is addressed again or cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous system reset |
| masterClr | input | 1 | Asynchronous active-high clear of all crosspoints |
| strobe | input | 1 | Asynchronous write strobe; the commit happens on its falling edge |
| dataIn | input | 1 | Value to commit to the addressed crosspoint |
| rowSel | input | 4 | Row code, 0 to 11 valid |
| colSel | input | 3 | Column code, 0 to 7 |
| switchEn | output | 96 | Enable bits, index colSel*12 + rowSel |
| badRow | output | 1 | One-cycle pulse: strobe named a row code of 12 or more |
| setupViol | output | 1 | One-cycle pulse: address changed while strobe high |

## Verification
The bench builds the block with its default parameters: 12 rows, 8 columns and two synchronizer stages. At this size every crosspoint can be set and cleared one at a time, and the full 96-bit vector is checked against an arithmetic model after each write. Every unused row code is also strobed on every column. Dedicated sequences cover the cases that only a fixed latency exposes. These are data moving around the strobe's falling edge, a clear that coincides with a falling edge, a clear held across a whole strobe, and an address moved mid-strobe.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  // Strobes issued by the control path to the latch array
  typedef struct packed {
    logic clearAll;
    logic writeEn;
    logic writeVal;
  } xptCtl_t;
endpackage

// File: rtl/xpt_ctrl.sv
module xpt_ctrl
  import xpt_pkg::*;
#(
  parameter int NUM_ROWS    = 12,
  parameter int ROW_W       = 4,
  parameter int COL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterClr,
  input  logic             strobe,
  input  logic             dataIn,
  input  logic [ROW_W-1:0] rowSel,
  input  logic [COL_W-1:0] colSel,
  output xptCtl_t          ctl,
  output logic [ROW_W-1:0] rowIdx,
  output logic [COL_W-1:0] colIdx,
  output logic             badRow,
  output logic             setupViol
);
  localparam int ADDR_W = ROW_W + COL_W;

  logic [SYNC_STAGES-1:0] strbPipe, dataPipe, clrPipe;
  logic [ADDR_W-1:0]      addrPipe [SYNC_STAGES];
  logic                   strobePrev;
  logic [ADDR_W-1:0]      addrPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strbPipe <= '0;
      dataPipe <= '0;
      clrPipe  <= '0;
      for (int i = 0; i < SYNC_STAGES; i++) addrPipe[i] <= '0;
    end else begin
      strbPipe[0] <= strobe;
      dataPipe[0] <= dataIn;
      clrPipe[0]  <= masterClr;
      addrPipe[0] <= {rowSel, colSel};
      for (int i = 1; i < SYNC_STAGES; i++) begin
        strbPipe[i] <= strbPipe[i-1];
        dataPipe[i] <= dataPipe[i-1];
        clrPipe[i]  <= clrPipe[i-1];
        addrPipe[i] <= addrPipe[i-1];
      end
    end
  end

  logic              strobeSync, dataSync, clrSync, fallEdge, rowOk;
  logic [ADDR_W-1:0] addrSync;

  assign strobeSync = strbPipe[SYNC_STAGES-1];
  assign dataSync   = dataPipe[SYNC_STAGES-1];
  assign clrSync    = clrPipe[SYNC_STAGES-1];
  assign addrSync   = addrPipe[SYNC_STAGES-1];
  assign rowIdx     = addrSync[ADDR_W-1:COL_W];
  assign colIdx     = addrSync[COL_W-1:0];
  assign fallEdge   = strobePrev & ~strobeSync;
  assign rowOk      = (int'(rowIdx) < NUM_ROWS);

  always_comb begin
    ctl.clearAll = clrSync;
    ctl.writeEn  = fallEdge & ~clrSync & rowOk;
    ctl.writeVal = dataSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobePrev <= 1'b0;
      addrPrev   <= '0;
      badRow     <= 1'b0;
      setupViol  <= 1'b0;
    end else begin
      strobePrev <= strobeSync;
      addrPrev   <= addrSync;
      badRow     <= fallEdge & ~clrSync & ~rowOk;
      setupViol  <= strobeSync & strobePrev & (addrSync != addrPrev) & ~clrSync;
    end
  end

  // R8
  bad_row_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    badRow |=> !badRow);
  // R8
  bad_row_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.writeEn |-> rowOk);
  // R9
  viol_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    setupViol |-> $past(strobeSync));
  // R7
  clear_blocks_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearAll |-> !ctl.writeEn);
endmodule

// File: rtl/xpt_array.sv
module xpt_array
  import xpt_pkg::*;
#(
  parameter int NUM_ROWS = 12,
  parameter int NUM_COLS = 8,
  parameter int ROW_W    = 4,
  parameter int COL_W    = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  xptCtl_t                      ctl,
  input  logic [ROW_W-1:0]             rowIdx,
  input  logic [COL_W-1:0]             colIdx,
  output logic [NUM_ROWS*NUM_COLS-1:0] switchEn
);
  localparam int NUM_BITS = NUM_ROWS * NUM_COLS;
  localparam int IDX_W    = $clog2(NUM_BITS);

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      localparam int K = c * NUM_ROWS + r;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          switchEn[K] <= 1'b0;
        else if (ctl.clearAll)
          switchEn[K] <= 1'b0;
        else if (ctl.writeEn && colIdx == COL_W'(c) && rowIdx == ROW_W'(r))
          switchEn[K] <= ctl.writeVal;
      end
    end
  end

  logic [IDX_W-1:0] flatIdx;
  assign flatIdx = IDX_W'(int'(colIdx) * NUM_ROWS + int'(rowIdx));

  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearAll |=> (switchEn == '0));
  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.writeEn && !ctl.clearAll) |=> $stable(switchEn));
  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeEn && !ctl.clearAll) |=> (switchEn[$past(flatIdx)] == $past(ctl.writeVal)));
  // R4
  single_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.clearAll |=> ($countones(switchEn ^ $past(switchEn)) <= 1));
endmodule

// File: rtl/xpt_latch_array.sv
module xpt_latch_array
  import xpt_pkg::*;
#(
  parameter int NUM_ROWS    = 12,
  parameter int NUM_COLS    = 8,
  parameter int ROW_W       = 4,
  parameter int COL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         masterClr,
  input  logic                         strobe,
  input  logic                         dataIn,
  input  logic [ROW_W-1:0]             rowSel,
  input  logic [COL_W-1:0]             colSel,
  output logic [NUM_ROWS*NUM_COLS-1:0] switchEn,
  output logic                         badRow,
  output logic                         setupViol
);
  xptCtl_t          ctl;
  logic [ROW_W-1:0] rowIdx;
  logic [COL_W-1:0] colIdx;

  xpt_ctrl #(
    .NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W), .COL_W(COL_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .masterClr(masterClr), .strobe(strobe),
    .dataIn(dataIn), .rowSel(rowSel), .colSel(colSel), .ctl(ctl),
    .rowIdx(rowIdx), .colIdx(colIdx), .badRow(badRow), .setupViol(setupViol)
  );

  xpt_array #(
    .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_array (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rowIdx(rowIdx), .colIdx(colIdx),
    .switchEn(switchEn)
  );
endmodule

// File: tb/sim_xpt_latch_array.sv
module sim_xpt_latch_array;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        masterClr = 1'b0;
  logic        strobe = 1'b0;
  logic        dataIn = 1'b0;
  logic [3:0]  rowSel = '0;
  logic [2:0]  colSel = '0;
  logic [95:0] switchEn;
  logic        badRow, setupViol;

  logic [95:0] model = '0;
  int checks = 0, fails = 0;
  int badCycles = 0, violCycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xpt_latch_array u0 (
    .clk(clk), .rstN(rstN), .masterClr(masterClr), .strobe(strobe),
    .dataIn(dataIn), .rowSel(rowSel), .colSel(colSel), .switchEn(switchEn),
    .badRow(badRow), .setupViol(setupViol)
  );

  always @(negedge clk) begin
    if (badRow) badCycles++;
    if (setupViol) violCycles++;
  end

  task automatic checkVec(input string tag);
    checks++;
    if (switchEn !== model) begin
      fails++;
      $display("FAIL %s: switchEn=%h expected=%h", tag, switchEn, model);
    end
  endtask

  task automatic checkInt(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Full strobe cycle with the address held steady
  task automatic doStrobe(input int row, input int col, input bit val);
    @(negedge clk);
    rowSel = 4'(row); colSel = 3'(col); dataIn = val;
    repeat (3) @(negedge clk);
    strobe = 1'b1;
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    int b0, v0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkVec("R1 reset vector");
    checkInt("R1 badRow at reset", int'(badRow), 0);
    checkInt("R1 setupViol at reset", int'(setupViol), 0);

    // R2, R4, R10: set each crosspoint in turn, whole vector vs model
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 12; r++) begin
        doStrobe(r, c, 1'b1);
        model[c*12 + r] = 1'b1;
        checkVec("R2 set sweep");
      end
    // R3, R10: clear every other crosspoint
    for (int k = 0; k < 96; k += 2) begin
      doStrobe(k % 12, k / 12, 1'b0);
      model[k] = 1'b0;
      checkVec("R3 clear sweep");
    end

    // R8: unused row codes on every column
    b0 = badCycles;
    for (int c = 0; c < 8; c++)
      for (int r = 12; r < 16; r++) begin
        doStrobe(r, c, (r % 2) == 1);
        checkVec("R8 bad row leaves bits");
      end
    checkInt("R8 badRow pulse cycles", badCycles - b0, 32);
    checkInt("R9 no violation on steady address", violCycles, 0);

    // R4: no change while strobe is held, and exact commit latency
    @(negedge clk);
    rowSel = 4'd0; colSel = 3'd0; dataIn = 1'b1;
    repeat (3) @(negedge clk);
    strobe = 1'b1;
    repeat (6) @(negedge clk);
    checkVec("R4 strobe high no change");
    strobe = 1'b0;
    repeat (2) @(negedge clk);
    checkVec("R2 not yet committed after two edges");
    @(negedge clk);
    model[0] = 1'b1;
    checkVec("R2 committed on third edge");

    // R5: data toggled while strobe high, then flipped right after the fall
    @(negedge clk);
    rowSel = 4'd5; colSel = 3'd3; dataIn = 1'b0;
    repeat (3) @(negedge clk);
    strobe = 1'b1;
    repeat (2) @(negedge clk);
    dataIn = 1'b1;
    repeat (2) @(negedge clk);
    dataIn = 1'b0;
    repeat (2) @(negedge clk);
    dataIn = 1'b1;
    repeat (2) @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
    dataIn = 1'b0;
    repeat (5) @(negedge clk);
    model[3*12 + 5] = 1'b1;
    checkVec("R5 value at falling edge kept");

    // R9: column moved while strobe high; the new address takes the write
    v0 = violCycles;
    @(negedge clk);
    rowSel = 4'd7; colSel = 3'd1; dataIn = 1'b1;
    repeat (3) @(negedge clk);
    strobe = 1'b1;
    repeat (3) @(negedge clk);
    colSel = 3'd6;
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    repeat (5) @(negedge clk);
    model[6*12 + 7] = 1'b1;
    checkInt("R9 setupViol pulse cycles", violCycles - v0, 1);
    checkVec("R9 write goes to moved address");

    // R6: clear all, then a full strobe while clear is held
    @(negedge clk);
    masterClr = 1'b1;
    repeat (4) @(negedge clk);
    model = '0;
    checkVec("R6 clear all");
    doStrobe(4, 2, 1'b1);
    checkVec("R6 strobe ignored under clear");
    masterClr = 1'b0;
    repeat (4) @(negedge clk);
    checkVec("R6 still clear after release");

    // R7: clear and strobe fall arrive in the same cycle
    doStrobe(1, 1, 1'b1);
    model[13] = 1'b1;
    checkVec("R7 setup bit");
    @(negedge clk);
    rowSel = 4'd2; colSel = 3'd4; dataIn = 1'b1;
    repeat (3) @(negedge clk);
    strobe = 1'b1;
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    masterClr = 1'b1;
    @(negedge clk);
    masterClr = 1'b0;
    repeat (6) @(negedge clk);
    model = '0;
    checkVec("R7 clear wins over write");

    // R10: persistence across unrelated writes
    doStrobe(11, 7, 1'b1);
    model[95] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      doStrobe(k, 0, 1'b1);
      model[k] = 1'b1;
    end
    checkVec("R10 bit 95 persists");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule